// File: doc/BRIEF.md
# Outer CHR Address Combiner with Bank Latch

This block builds the upper pattern-memory address bits A20..A10 for a cartridge-style banking controller. It takes three inputs: the PPU's A12..A10, a 1 KiB inner bank number from the inner bank controller, and the mode bits set by the outer configuration logic. It then decides which bits come from a CHR base register, which come from the inner bank, which come from a small CHR latch and which come straight from the PPU. The base register and the latch live inside the block, together with the logic that writes them.

The CPU loads the base register through a decoded select. The register window decoder upstream raises `base_sel` for that write. In latch mode, any CPU write whose address has A15 set loads the latch from data bits 1..0. Loading the base register always clears the latch. The combined address is registered, so `chr_a` follows its inputs one clock later.

Top module: `chr_outer_map`

## Requirements
- R1: A synchronous reset clears the base register, the latch and `chr_a` to zero.
- R2: In inner banking (`latch_mode`=0, `ext_mode`=0) with `size_small`=0, `chr_a` = {base[7:5], inner_bank[7:0]}.
- R3: In inner banking with `size_small`=1, `chr_a` = {base[7:4], inner_bank[6:0]}.
- R4: With `latch_mode`=1, `latch_off`=0 and `size_small`=0, `chr_a` = {base[7:2], latch[1:0], ppu_a[2:0]}.
- R5: With `latch_mode`=1, `latch_off`=0 and `size_small`=1, `chr_a` = {base[7:1], latch[0], ppu_a[2:0]}.
- R6: With `latch_mode`=1 and `latch_off`=1, `chr_a` = {base[7:0], ppu_a[2:0]}, whatever the latch holds.
- R7: With `ext_mode`=1 and `latch_mode`=0, `chr_a` = {base, 3'b000} | {3'b000, inner_bank}, and `size_small` has no effect. With `latch_mode`=1, `ext_mode` is ignored.
- R8: A write with `cpu_wr`=1, `base_sel`=0, `cpu_addr[15]`=1 and `latch_mode`=1 loads the latch from `cpu_data[1:0]`. A write with `cpu_addr[15]`=0, or one made while `latch_mode`=0, leaves the latch unchanged.
- R9: A write with `cpu_wr`=1 and `base_sel`=1 loads the base register from `cpu_data[7:0]` and clears the latch to 0 in the same edge.
- R10: `chr_a` is registered: a change on any input appears on `chr_a` after the next rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| base_sel | input | 1 | Decoded select: this write targets the CHR base register |
| latch_mode | input | 1 | 1: latch/fixed CHR mode, 0: inner banking |
| latch_off | input | 1 | In latch mode, 1 removes the latch from the address |
| size_small | input | 1 | Outer size select (0: large, 1: small) |
| ext_mode | input | 1 | Extended banking: OR of full base and full inner bank |
| inner_bank | input | 8 | 1 KiB inner bank number from the inner controller |
| ppu_a | input | 3 | PPU address A12..A10 |
| chr_a | output | 11 | CHR address A20..A10 (bit 0 is A10) |

## Verification
The assertions assume `cpu_wr` is a single-cycle strobe. They also assume `base_sel` is never raised together with a latch-range write to the same register, and that the mode bits hold steady across the edge at which `chr_a` is sampled. The bench changes every input on the falling edge and holds each write strobe for exactly one rising edge. It reaches the latch only through writes with A15 set, or through a base register write that clears it. It switches modes only between checks, so each expected word depends on one settled mode.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;

  // Which source arrangement feeds the CHR address word
  typedef enum logic [1:0] {
    SRC_INNER     = 2'd0,
    SRC_INNER_EXT = 2'd1,
    SRC_LATCH     = 2'd2,
    SRC_FIXED     = 2'd3
  } chr_src_e;

  function automatic chr_src_e pick_src(input logic latch_mode,
                                        input logic latch_off,
                                        input logic ext_mode);
    if (latch_mode) return latch_off ? SRC_FIXED : SRC_LATCH;
    return ext_mode ? SRC_INNER_EXT : SRC_INNER;
  endfunction

endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs #(
  parameter int BASE_W  = 8,
  parameter int LATCH_W = 2,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_wr,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_data,
  input  logic               base_sel,
  input  logic               latch_mode,
  output logic [BASE_W-1:0]  base_q,
  output logic [LATCH_W-1:0] latch_q
);

  localparam int HI_BIT = ADDR_W - 1;

  logic base_we;
  logic latch_we;

  assign base_we  = cpu_wr && base_sel;
  assign latch_we = cpu_wr && !base_sel && latch_mode && cpu_addr[HI_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      latch_q <= '0;
    end else if (base_we) begin
      base_q  <= cpu_data[BASE_W-1:0];
      latch_q <= '0;
    end else if (latch_we) begin
      latch_q <= cpu_data[LATCH_W-1:0];
    end
  end

  // R9: a base write clears the latch
  p_base_clears_latch_r9: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && base_sel) |=> (latch_q == '0));

  // R9: a base write loads the data
  p_base_loads_r9: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && base_sel) |=> (base_q == $past(cpu_data[BASE_W-1:0])));

  // R8: a latch-range write in latch mode loads data bits 1..0
  p_latch_load_r8: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !base_sel && latch_mode && cpu_addr[HI_BIT])
      |=> (latch_q == $past(cpu_data[LATCH_W-1:0])));

  // R8: other writes leave the latch alone
  p_latch_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!base_sel && !(cpu_wr && latch_mode && cpu_addr[HI_BIT])) |=> $stable(latch_q));

endmodule

// File: rtl/chr_addr_mux.sv
module chr_addr_mux
  import chr_map_pkg::*;
#(
  parameter int BASE_W  = 8,
  parameter int INNER_W = 8,
  parameter int LATCH_W = 2,
  parameter int PPU_W   = 3,
  parameter int OUT_W   = BASE_W + PPU_W
) (
  input  logic [BASE_W-1:0]  base_q,
  input  logic [LATCH_W-1:0] latch_q,
  input  logic [INNER_W-1:0] inner_bank,
  input  logic [PPU_W-1:0]   ppu_a,
  input  logic               latch_mode,
  input  logic               latch_off,
  input  logic               size_small,
  input  logic               ext_mode,
  output logic [OUT_W-1:0]   chr_next
);

  // Inner bank field: full width for the large outer size, one bit less for the small
  localparam logic [OUT_W-1:0] INNER_MASK_L = OUT_W'((1 << INNER_W) - 1);
  localparam logic [OUT_W-1:0] INNER_MASK_S = OUT_W'((1 << (INNER_W - 1)) - 1);
  // Latch field sits just above the PPU bits; the small size keeps only its low bit
  localparam logic [OUT_W-1:0] LATCH_MASK_L = OUT_W'(((1 << LATCH_W) - 1) << PPU_W);
  localparam logic [OUT_W-1:0] LATCH_MASK_S = OUT_W'(((1 << (LATCH_W - 1)) - 1) << PPU_W);

  logic [OUT_W-1:0] base_word;
  logic [OUT_W-1:0] inner_word;
  logic [OUT_W-1:0] latch_word;
  logic [OUT_W-1:0] fixed_word;
  logic [OUT_W-1:0] inner_mask;
  logic [OUT_W-1:0] latch_mask;
  chr_src_e         src;

  assign base_word  = {base_q, {PPU_W{1'b0}}};
  assign inner_word = OUT_W'(inner_bank);
  assign latch_word = OUT_W'(latch_q) << PPU_W;
  assign fixed_word = base_word | OUT_W'(ppu_a);
  assign inner_mask = size_small ? INNER_MASK_S : INNER_MASK_L;
  assign latch_mask = size_small ? LATCH_MASK_S : LATCH_MASK_L;
  assign src        = pick_src(latch_mode, latch_off, ext_mode);

  always_comb begin
    unique case (src)
      SRC_INNER:     chr_next = (base_word & ~inner_mask) | (inner_word & inner_mask);
      SRC_INNER_EXT: chr_next = base_word | inner_word;
      SRC_LATCH:     chr_next = (fixed_word & ~latch_mask) | (latch_word & latch_mask);
      default:       chr_next = fixed_word;
    endcase
  end

endmodule

// File: rtl/chr_outer_map.sv
module chr_outer_map #(
  parameter int BASE_W  = 8,
  parameter int INNER_W = 8,
  parameter int LATCH_W = 2,
  parameter int PPU_W   = 3,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cpu_wr,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [DATA_W-1:0]         cpu_data,
  input  logic                      base_sel,
  input  logic                      latch_mode,
  input  logic                      latch_off,
  input  logic                      size_small,
  input  logic                      ext_mode,
  input  logic [INNER_W-1:0]        inner_bank,
  input  logic [PPU_W-1:0]          ppu_a,
  output logic [BASE_W+PPU_W-1:0]   chr_a
);

  localparam int OUT_W = BASE_W + PPU_W;

  logic [BASE_W-1:0]  base_q;
  logic [LATCH_W-1:0] latch_q;
  logic [OUT_W-1:0]   chr_next;

  chr_bank_regs #(
    .BASE_W (BASE_W),
    .LATCH_W(LATCH_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_data  (cpu_data),
    .base_sel  (base_sel),
    .latch_mode(latch_mode),
    .base_q    (base_q),
    .latch_q   (latch_q)
  );

  chr_addr_mux #(
    .BASE_W (BASE_W),
    .INNER_W(INNER_W),
    .LATCH_W(LATCH_W),
    .PPU_W  (PPU_W),
    .OUT_W  (OUT_W)
  ) u_mux (
    .base_q    (base_q),
    .latch_q   (latch_q),
    .inner_bank(inner_bank),
    .ppu_a     (ppu_a),
    .latch_mode(latch_mode),
    .latch_off (latch_off),
    .size_small(size_small),
    .ext_mode  (ext_mode),
    .chr_next  (chr_next)
  );

  always_ff @(posedge clk) begin
    if (rst) chr_a <= '0;
    else     chr_a <= chr_next;
  end

  // R1: reset leaves a zero address
  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (chr_a == '0));

  // R4, R5 and R6: the PPU bits pass straight through in latch mode
  p_ppu_pass_r6: assert property (@(posedge clk) disable iff (rst)
    latch_mode |=> (chr_a[PPU_W-1:0] == $past(ppu_a)));

  // R6: with the latch removed, the top bits are the base register
  p_fixed_base_r6: assert property (@(posedge clk) disable iff (rst)
    (latch_mode && latch_off && !cpu_wr) |=> (chr_a[OUT_W-1:PPU_W] == $past(base_q)));

  // R7: in extended mode every set inner bit reaches the address
  p_ext_or_r7: assert property (@(posedge clk) disable iff (rst)
    (ext_mode && !latch_mode) |=>
      ((chr_a[INNER_W-1:0] & $past(inner_bank)) == $past(inner_bank)));

endmodule

// File: tb/tb_chr_outer_map.sv
module tb_chr_outer_map;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        base_sel = 1'b0;
  logic        latch_mode = 1'b0;
  logic        latch_off = 1'b0;
  logic        size_small = 1'b0;
  logic        ext_mode = 1'b0;
  logic [7:0]  inner_bank = '0;
  logic [2:0]  ppu_a = '0;
  logic [10:0] chr_a;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  chr_outer_map dut (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .base_sel(base_sel), .latch_mode(latch_mode), .latch_off(latch_off),
    .size_small(size_small), .ext_mode(ext_mode), .inner_bank(inner_bank),
    .ppu_a(ppu_a), .chr_a(chr_a)
  );

  // {req[3:0], base[7:0], latch[1:0], lm, loff, small, ext, inner[7:0], ppu[2:0], expected[10:0]}
  localparam int NVEC = 11;
  localparam logic [39:0] VEC [NVEC] = '{
    {4'd2,  8'hA5, 2'd0, 4'b0000, 8'h3C, 3'd0, 11'h53C}, // R2
    {4'd2,  8'h1F, 2'd0, 4'b0000, 8'hFF, 3'd0, 11'h0FF}, // R2
    {4'd3,  8'hA5, 2'd0, 4'b0010, 8'hFF, 3'd0, 11'h57F}, // R3
    {4'd3,  8'h3C, 2'd0, 4'b0010, 8'h80, 3'd0, 11'h180}, // R3
    {4'd4,  8'hA5, 2'd2, 4'b1000, 8'h00, 3'd5, 11'h535}, // R4
    {4'd5,  8'hA5, 2'd3, 4'b1010, 8'h00, 3'd2, 11'h52A}, // R5
    {4'd5,  8'hA4, 2'd2, 4'b1010, 8'h00, 3'd7, 11'h527}, // R5
    {4'd6,  8'hA5, 2'd3, 4'b1100, 8'h00, 3'd6, 11'h52E}, // R6
    {4'd7,  8'hA5, 2'd0, 4'b0001, 8'hC3, 3'd0, 11'h5EB}, // R7
    {4'd7,  8'hA5, 2'd0, 4'b0011, 8'hC3, 3'd0, 11'h5EB}, // R7 size ignored
    {4'd7,  8'hA5, 2'd1, 4'b1101, 8'hC3, 3'd1, 11'h529}  // R7 ext ignored in latch mode
  };

  task automatic check(input string req, input logic [10:0] exp);
    checks++;
    if (chr_a !== exp) begin
      errors++;
      $display("FAIL %s: chr_a=%h expected %h", req, chr_a, exp);
    end
  endtask

  task automatic cpu_write(input logic sel, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; base_sel = sel; cpu_addr = a; cpu_data = d;
    @(negedge clk);
    cpu_wr = 1'b0; base_sel = 1'b0;
  endtask

  // Base write (clears latch), then latch write in latch mode
  task automatic load_state(input logic [7:0] b, input logic [1:0] l);
    @(negedge clk);
    latch_mode = 1'b1;
    cpu_write(1'b1, 16'h5002, b);
    cpu_write(1'b0, 16'h8000, {6'd0, l});
  endtask

  task automatic set_modes(input logic lm, input logic lo, input logic sm, input logic ex,
                           input logic [7:0] inb, input logic [2:0] pa);
    @(negedge clk);
    latch_mode = lm; latch_off = lo; size_small = sm; ext_mode = ex;
    inner_bank = inb; ppu_a = pa;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 during reset", 11'h000);
    rst = 1'b0;

    // R1: state after reset seen through the fixed arrangement
    set_modes(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0);
    check("R1 base and latch zero", 11'h000);

    // Table walk: R2..R7
    for (int i = 0; i < NVEC; i++) begin
      logic [39:0] v;
      string tag;
      v = VEC[i];
      load_state(v[35:28], v[27:26]);
      set_modes(v[25], v[24], v[23], v[22], v[21:14], v[13:11]);
      tag = $sformatf("R%0d vec %0d", v[39:36], i);
      check(tag, v[10:0]);
    end

    // R8: latch load from any address with A15 set
    load_state(8'h00, 2'd1);
    set_modes(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0);
    cpu_write(1'b0, 16'hFFFF, 8'hFE);
    @(negedge clk);
    check("R8 load at top of range", 11'h010);

    // R8: A15 clear is ignored
    cpu_write(1'b0, 16'h7FFF, 8'h03);
    @(negedge clk);
    check("R8 low address ignored", 11'h010);

    // R8: write outside latch mode is ignored
    set_modes(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0);
    cpu_write(1'b0, 16'h8000, 8'h01);
    set_modes(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0);
    check("R8 inner-mode write ignored", 11'h010);

    // R9: base write loads base and clears latch
    cpu_write(1'b0, 16'hC000, 8'h03);
    @(negedge clk);
    check("R9 latch preset", 11'h018);
    cpu_write(1'b1, 16'h5002, 8'h40);
    @(negedge clk);
    check("R9 base loaded, latch cleared", 11'h200);

    // R10: output changes only after a rising edge
    set_modes(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 3'd1);
    check("R10 settled", 11'h201);
    @(posedge clk);
    #2 ppu_a = 3'd6;
    #1 check("R10 no change before edge", 11'h201);
    @(posedge clk);
    #1 check("R10 change after edge", 11'h206);

    // R1: reset clears loaded state
    load_state(8'hFF, 2'd3);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    set_modes(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0);
    check("R1 reset clears state", 11'h000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule